// File: doc/BRIEF.md
# Prioritized Mixed-Trigger Interrupt Controller

This block sits in front of a small 8-bit processor core and turns four raw request lines into a single prioritized interrupt offer. One input is a general request that carries no vector of its own. The other three are vectored restart requests. The top vectored line is captured on its rising edge, so a short pulse is not lost. The two lower vectored lines and the general line are sampled by level. Pending requests are held in a request register. Each vectored source has its own mask bit, and a global enable bit and an in-service flag gate dispatch.

The core sees one offer at a time: a valid flag, a 16-bit restart address or a general-request indication, the global enable and the in-service flag. It takes the offer with an acknowledge strobe. An enable-interrupts strobe retires the request in service, sets the global enable and samples the lines again. A separate end-of-service strobe drops the in-service flag without touching the global enable. A mask-write port loads all three vectored mask bits at once.

Top module: `irq_front`

## Requirements
- R1: After reset nothing is pending, the global enable and the in-service flag are 0, all three vectored masks are set (1 = masked) and `int_valid_o` is 0.
- R2: A rising edge on `req_vec_i[2]` is latched and enters the request register on the next clock, and stays pending after the line falls. The latch is emptied by that transfer, so a line held high produces exactly one request until it falls and rises again.
- R3: `req_gen_i`, `req_vec_i[0]` and `req_vec_i[1]` set their pending bits while asserted. When such a line is low while the global enable is 0, its pending bit clears on that clock. While the enable is 1, the bit is kept.
- R4: A pending vectored request whose mask bit is 1 stays pending but is not offered. Once the mask is cleared it is offered. `mask_i` bit k masks `req_vec_i[k]`, and it is loaded when `mask_we_i` is 1.
- R5: Fixed priority, from highest to lowest: `req_vec_i[2]` (vector 0x003C), `req_vec_i[1]` (0x0034), `req_vec_i[0]` (0x002C), the general request. A general offer sets `int_gen_o` with `int_vec_o` = 0. `int_vec_o` is 0 whenever nothing is offered.
- R6: `int_valid_o` is 1 only when the global enable is 1, nothing is in service, and at least one unmasked request is pending.
- R7: An `ack_i` taken while `int_valid_o` is 1 clears the global enable, sets the in-service flag and clears the offered source's pending bit, all on the next clock.
- R8: `ei_i` sets the global enable and clears the in-service flag. It also drops the pending bit of the source in service, unless that source's line is still asserted (level sources) or its latch holds a new edge.
- R9: `eos_i` clears the in-service flag and leaves the global enable and the pending bits as they are.
- R10: When `ei_i` and `ack_i` arrive in the same cycle, `ei_i` takes effect and the acknowledge is ignored.
- R11: An `ack_i` while `int_valid_o` is 0 changes neither the in-service flag nor the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_gen_i | input | 1 | General level-sensitive request |
| req_vec_i | input | 3 | Vectored requests; bit 2 edge-latched, bits 1..0 level-sampled |
| ei_i | input | 1 | Enable-interrupts strobe |
| mask_we_i | input | 1 | Mask write strobe |
| mask_i | input | 3 | New mask bits, 1 = masked |
| ack_i | input | 1 | Core takes the current offer |
| eos_i | input | 1 | End-of-service strobe |
| int_valid_o | output | 1 | An interrupt is offered |
| int_vec_o | output | 16 | Restart address of the offer, 0 for general or none |
| int_gen_o | output | 1 | The offer is the general request |
| int_en_o | output | 1 | Global enable state |
| in_serv_o | output | 1 | A request is in service |

## Verification
Three collisions matter here. An enable-interrupts strobe can meet an acknowledge, and the enable strobe must win (R10). An acknowledge can clear the top pending bit in the same cycle that a fresh edge is transferring in, and the new edge must survive. An enable strobe can retire the serviced bit while that source's line is still high, and the level sample must win. Directed sequences build each collision on purpose. Random strobes and toggling lines then hit them at random. Every cycle is compared against a cycle-level model of the requirements kept in the bench.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int VEC_W    = 16;
  localparam int VEC_BASE = 'h24;
  localparam int VEC_STEP = 'h08;

  // Restart address for priority index idx (idx 0 is the general request).
  function automatic logic [VEC_W-1:0] vec_at(input int idx);
    vec_at = VEC_W'(VEC_BASE + VEC_STEP * idx);
  endfunction

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/irq_edge_cap.sv
module irq_edge_cap (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic latch_o
);

  logic line_q;
  logic latch_q;
  logic latch_d;

  // The latch is emptied by its transfer on the next clock, so it only
  // holds the one cycle that follows a rising edge.
  always_comb begin
    latch_d = line_i & ~line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      line_q  <= line_i;
      latch_q <= latch_d;
    end
  end

  assign latch_o = latch_q;

  AST_EDGE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q |=> !latch_q); // R2

endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-2:0] lvl_i,
  input  logic            edge_i,
  input  logic            ien_i,
  input  logic [NSRC-1:0] ack_clr_i,
  input  logic [NSRC-1:0] svc_clr_i,
  output logic [NSRC-1:0] pend_o
);

  localparam int TOP = NSRC - 1;

  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;

  // Level sources: ack clear wins over the live line; the line wins over a
  // service clear; a low line drops the bit while interrupts are disabled.
  for (genvar i = 0; i < TOP; i++) begin : g_lvl
    assign pend_d[i] = ack_clr_i[i] ? 1'b0 :
                       lvl_i[i]     ? 1'b1 :
                       svc_clr_i[i] ? 1'b0 :
                       (ien_i & pend_q[i]);

    AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (!ien_i && !lvl_i[i]) |=> !pend_q[i]); // R3
  end

  // Edge source: a freshly latched edge wins over any clear.
  assign pend_d[TOP] = edge_i ? 1'b1 :
                       (ack_clr_i[TOP] | svc_clr_i[TOP]) ? 1'b0 :
                       pend_q[TOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  AST_EDGE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    edge_i |=> pend_q[TOP]); // R2

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            cand_i,
  output logic                       any_o,
  output logic [NSRC-1:0]            grant_o,
  output logic [irq_pkg::VEC_W-1:0]  vec_o
);

  logic [NSRC-1:0]           grant;
  logic [irq_pkg::VEC_W-1:0] vec;

  // Later (higher) indices overwrite lower ones: fixed priority to the top.
  always_comb begin
    grant = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand_i[i]) grant = {{(NSRC-1){1'b0}}, 1'b1} << i;
    end
  end

  always_comb begin
    vec = '0;
    for (int i = 1; i < NSRC; i++) begin
      if (grant[i]) vec = irq_pkg::vec_at(i);
    end
  end

  assign grant_o = grant;
  assign vec_o   = vec;
  assign any_o   = |cand_i;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ($onehot0(grant_o) && grant_o != '0)); // R5

endmodule

// File: rtl/irq_front.sv
module irq_front #(
  parameter int NUM_VEC = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_gen_i,
  input  logic [NUM_VEC-1:0]        req_vec_i,
  input  logic                      ei_i,
  input  logic                      mask_we_i,
  input  logic [NUM_VEC-1:0]        mask_i,
  input  logic                      ack_i,
  input  logic                      eos_i,
  output logic                      int_valid_o,
  output logic [irq_pkg::VEC_W-1:0] int_vec_o,
  output logic                      int_gen_o,
  output logic                      int_en_o,
  output logic                      in_serv_o
);

  localparam int NSRC = NUM_VEC + 1;
  localparam int TOP  = NSRC - 1;

  logic                      rst_sync_n;
  logic                      edge_latch;
  logic [NSRC-1:0]           req_all;
  logic [NSRC-1:0]           pend;
  logic [NSRC-1:0]           cand;
  logic [NSRC-1:0]           grant;
  logic                      any_cand;
  logic [irq_pkg::VEC_W-1:0] pick_vec;
  logic                      offer;
  logic                      ack_eff;
  logic [NSRC-1:0]           ack_clr;
  logic [NSRC-1:0]           svc_clr;

  logic                      ien_q, ien_d, ien_en;
  logic [NUM_VEC-1:0]        mask_q, mask_d, mask_en;
  logic [NSRC-1:0]           srv_q, srv_d;
  logic                      srv_en;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_edge_cap u_edge (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .line_i  (req_vec_i[NUM_VEC-1]),
    .latch_o (edge_latch)
  );

  assign req_all = {req_vec_i, req_gen_i};

  irq_pend #(.NSRC(NSRC)) u_pend (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .lvl_i     (req_all[NSRC-2:0]),
    .edge_i    (edge_latch),
    .ien_i     (ien_q),
    .ack_clr_i (ack_clr),
    .svc_clr_i (svc_clr),
    .pend_o    (pend)
  );

  assign cand = pend & {~mask_q, 1'b1};

  irq_pick #(.NSRC(NSRC)) u_pick (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cand_i  (cand),
    .any_o   (any_cand),
    .grant_o (grant),
    .vec_o   (pick_vec)
  );

  assign offer   = ien_q & ~(|srv_q) & any_cand;
  assign ack_eff = ack_i & offer & ~ei_i;
  assign ack_clr = ack_eff ? grant : '0;
  assign svc_clr = ei_i ? srv_q : '0;

  // Next-state logic with explicit clock enables.
  always_comb begin
    ien_en  = ei_i | ack_eff;
    ien_d   = ei_i;
    mask_en = mask_we_i;
    mask_d  = mask_i;
    srv_en  = ei_i | ack_eff | eos_i;
    srv_d   = (ack_eff && !ei_i) ? grant : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ien_q  <= 1'b0;
      mask_q <= '1;
      srv_q  <= '0;
    end else begin
      if (ien_en)  ien_q  <= ien_d;
      if (mask_en) mask_q <= mask_d;
      if (srv_en)  srv_q  <= srv_d;
    end
  end

  assign int_valid_o = offer;
  assign int_gen_o   = offer & grant[0];
  assign int_vec_o   = offer ? pick_vec : '0;
  assign int_en_o    = ien_q;
  assign in_serv_o   = |srv_q;

  AST_ACK_TAKES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ack_eff |=> (in_serv_o && !int_en_o)); // R7

  AST_SERVICE_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(in_serv_o) |-> $past(ack_i && int_valid_o && !ei_i)); // R7

  AST_EI_REOPENS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ei_i |=> (int_en_o && !in_serv_o)); // R8

  AST_EOS_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eos_i && !ei_i && !ack_eff) |=> (!in_serv_o && $stable(int_en_o))); // R9

  AST_EI_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ei_i && ack_i) |=> !in_serv_o); // R10

  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack_i && !int_valid_o && !ei_i && !eos_i) |=> ($stable(in_serv_o) && $stable(int_en_o))); // R11

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pend[TOP] && !ack_clr[TOP] && !svc_clr[TOP]) |=> pend[TOP]); // R4

endmodule

// File: tb/irq_front_bench.sv
module irq_front_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_gen;
  logic [2:0]  req_vec;
  logic        ei, mask_we, ack, eos;
  logic [2:0]  mask_w;
  logic        int_valid, int_gen, int_en, in_serv;
  logic [15:0] int_vec;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  irq_front u_irq_front (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_gen_i   (req_gen),
    .req_vec_i   (req_vec),
    .ei_i        (ei),
    .mask_we_i   (mask_we),
    .mask_i      (mask_w),
    .ack_i       (ack),
    .eos_i       (eos),
    .int_valid_o (int_valid),
    .int_vec_o   (int_vec),
    .int_gen_o   (int_gen),
    .int_en_o    (int_en),
    .in_serv_o   (in_serv)
  );

  // Requirement model: index 3 = edge line, 2..1 = level vectored, 0 = general.
  logic [3:0] m_pend;
  logic       m_latch, m_v3q, m_ien;
  logic [2:0] m_mask;
  logic [3:0] m_srv;

  function automatic logic [3:0] m_grant();
    logic [3:0] c;
    c = m_pend & {~m_mask, 1'b1};
    if (c[3])      return 4'b1000;
    else if (c[2]) return 4'b0100;
    else if (c[1]) return 4'b0010;
    else if (c[0]) return 4'b0001;
    return 4'b0000;
  endfunction

  function automatic logic m_valid();
    return m_ien && (m_srv == 4'b0) && (m_grant() != 4'b0);
  endfunction

  function automatic logic [15:0] m_vec();
    if (!m_valid()) return 16'h0000;
    case (m_grant())
      4'b1000: return 16'h003C;
      4'b0100: return 16'h0034;
      4'b0010: return 16'h002C;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_reset();
    m_pend = '0; m_latch = 0; m_v3q = 0; m_ien = 0; m_mask = 3'b111; m_srv = '0;
  endtask

  task automatic model_step();
    logic [3:0] g, aclr, sclr, np, lines;
    logic       acc;
    g     = m_grant();
    acc   = ack && m_valid() && !ei;
    aclr  = acc ? g : 4'b0;
    sclr  = ei ? m_srv : 4'b0;
    lines = {1'b0, req_vec[1:0], req_gen};
    for (int i = 0; i < 3; i++) begin
      if (aclr[i])       np[i] = 1'b0;
      else if (lines[i]) np[i] = 1'b1;
      else if (sclr[i])  np[i] = 1'b0;
      else               np[i] = m_ien & m_pend[i];
    end
    if (m_latch)                  np[3] = 1'b1;
    else if (aclr[3] || sclr[3])  np[3] = 1'b0;
    else                          np[3] = m_pend[3];
    m_pend  = np;
    m_latch = req_vec[2] && !m_v3q;
    m_v3q   = req_vec[2];
    if (mask_we) m_mask = mask_w;
    if (ei)        begin m_ien = 1; m_srv = '0; end
    else if (acc)  begin m_ien = 0; m_srv = g;  end
    else if (eos)  m_srv = '0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk({cur_tag, " R6 valid"}, 32'(int_valid), 32'(m_valid()));
    chk({cur_tag, " R5 vector"}, 32'(int_vec), 32'(m_vec()));
    chk({cur_tag, " R5 general"}, 32'(int_gen), 32'(m_valid() && m_grant() == 4'b0001));
    chk({cur_tag, " R8 enable"}, 32'(int_en), 32'(m_ien));
    chk({cur_tag, " R7 in service"}, 32'(in_serv), 32'(m_srv != 4'b0));
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare();
    ei = 0; ack = 0; eos = 0; mask_we = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_gen = 0; req_vec = 0; ei = 0; mask_we = 0; mask_w = 0; ack = 0; eos = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    cur_tag = "R1";
    chk("R1 valid", 32'(int_valid), 0);
    chk("R1 enable", 32'(int_en), 0);
    chk("R1 in service", 32'(in_serv), 0);
    req_vec[0] = 1; ei = 1; tick(); tick();
    chk("R1 masked after reset", 32'(int_valid), 0);

    // R4: unmask releases the held request
    cur_tag = "R4";
    mask_we = 1; mask_w = 3'b000; tick();
    chk("R4 unmasked offer", 32'(int_vec), 32'h002C);

    // R2/R5: short pulse on the edge line outranks the level request
    cur_tag = "R2";
    req_vec[2] = 1; tick(); req_vec[2] = 0; tick();
    chk("R2 pulse latched", 32'(int_vec), 32'h003C);
    tick();
    chk("R2 held after drop", 32'(int_vec), 32'h003C);

    // R7: acknowledge
    cur_tag = "R7";
    ack = 1; tick();
    chk("R7 in service", 32'(in_serv), 1);
    chk("R7 enable cleared", 32'(int_en), 0);
    chk("R7 no offer", 32'(int_valid), 0);

    // R8: re-enable retires edge request, level line still offered
    cur_tag = "R8";
    ei = 1; tick();
    chk("R8 lower offered", 32'(int_vec), 32'h002C);

    // R2: held-high edge line gives a single request
    cur_tag = "R2";
    req_vec[2] = 1; tick(); tick();
    chk("R2 first", 32'(int_vec), 32'h003C);
    ack = 1; tick(); ei = 1; tick(); tick();
    chk("R2 no repeat while high", 32'(int_vec), 32'h002C);

    // R3: level line dropped while disabled vanishes
    cur_tag = "R3";
    req_vec[2] = 0; ack = 1; tick();
    req_vec[0] = 0; tick();
    ei = 1; tick();
    chk("R3 dropped while disabled", 32'(int_valid), 0);
    req_vec[1] = 1; tick(); req_vec[1] = 0; tick();
    chk("R3 kept while enabled", 32'(int_vec), 32'h0034);

    // R10: enable and acknowledge together
    cur_tag = "R10";
    ei = 1; ack = 1; tick();
    chk("R10 ack ignored", 32'(in_serv), 0);
    chk("R10 still offered", 32'(int_vec), 32'h0034);

    // R9: end of service leaves enable off
    cur_tag = "R9";
    ack = 1; tick();
    eos = 1; tick();
    chk("R9 service cleared", 32'(in_serv), 0);
    chk("R9 enable kept", 32'(int_en), 0);

    // R11: idle acknowledge; R5 general request
    cur_tag = "R11";
    ack = 1; tick();
    chk("R11 no service", 32'(in_serv), 0);
    cur_tag = "R5";
    req_gen = 1; ei = 1; tick();
    chk("R5 general flag", 32'(int_gen), 1);
    chk("R5 general vector", 32'(int_vec), 0);
    ack = 1; req_gen = 0; tick(); ei = 1; tick();

    // Random phase
    cur_tag = "RND";
    void'($urandom(32'h5EED_0017));
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(7) == 0) req_gen    = ~req_gen;
      if ($urandom_range(7) == 0) req_vec[0] = ~req_vec[0];
      if ($urandom_range(7) == 0) req_vec[1] = ~req_vec[1];
      if ($urandom_range(5) == 0) req_vec[2] = ~req_vec[2];
      ei      = ($urandom_range(11) == 0);
      ack     = ($urandom_range(3) == 0);
      eos     = ($urandom_range(15) == 0);
      mask_we = ($urandom_range(23) == 0);
      mask_w  = 3'($urandom_range(7));
      tick();
    end

    done = 1;
    summary();
    $finish;
  end

endmodule